// File: doc/BRIEF.md
# Flag-setting bitwise logic unit

This block executes one of six bitwise operations on two operands, plus a flags-only test. The result goes into an output register. The block can also update a small condition-flag register holding Negative, Zero and Carry. The surrounding datapath supplies an operation code and two operands. It also supplies a control that asks for the flags to be updated, the carry bit produced by an upstream shifter, and a valid strobe. One clock edge later the block returns the result, a write enable for the destination, and the updated flags.

The operations cover the plain combinations AND, OR and XOR, and a bit-clear that ANDs with the inverted second operand. They also include an or-with-inverted-second-operand and a pure complement of the second operand. The test operation ANDs the operands to set the flags but never requests a write. This makes it the natural way to probe a single bit through a one-hot mask: Zero set means the probed bit was 0.

Top module: `bitlogic_unit`

## Requirements
- R1: Operation code 0 yields opa & opb, code 1 yields opa | opb, and code 2 yields opa ^ opb.
- R2: Operation code 3 (bit clear) yields opa & ~opb, so every 1 in opb forces the matching result bit to 0.
- R3: Operation code 4 yields opa | ~opb.
- R4: Operation code 5 yields ~opb, and the value of opa has no effect on the result.
- R5: The flag register loads only on a valid cycle where set_flags_i is 1 or the code is 6. On every other cycle the three flags keep their value.
- R6: Operation code 6 (test) loads the flags from opa & opb whatever set_flags_i is. It leaves result_we_o at 0 and result_o unchanged.
- R7: On a flag load, N takes the most significant bit of the computed value, and Z is 1 exactly when every bit of that value is 0.
- R8: On a flag load, C takes the value of shift_carry_i.
- R9: While rst_n is 0, result_o, result_we_o and all flags are 0.
- R10: result_o and result_we_o appear one clock after the valid cycle. result_we_o is 0 after a cycle without valid, and result_o then holds its last written value.
- R11: Operation code 7 is reserved. It writes no result and changes no flag, even when set_flags_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation code (0..7) |
| opa_i | input | WIDTH | First operand |
| opb_i | input | WIDTH | Second operand |
| set_flags_i | input | 1 | Request flag update |
| shift_carry_i | input | 1 | Carry from the shifter stage |
| result_o | output | WIDTH | Registered result |
| result_we_o | output | 1 | Result write enable, registered |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
Every output of this block is due exactly one rising edge after the cycle that presents the operation. This applies to the result, its write enable and the three flags. The bench drives inputs on the falling edge. It advances its behavioural model on the following rising edge, and compares all five outputs one nanosecond later, so each comparison sees the state written by that single edge. Cycles with valid low, with the reserved code, or with set_flags low show up in the model as held values. This exposes any stray update in the very next comparison.

// File: rtl/lu_pkg.sv
package lu_pkg;
   typedef enum logic [2:0] {
      LOP_AND = 3'd0,
      LOP_ORR = 3'd1,
      LOP_EOR = 3'd2,
      LOP_BIC = 3'd3,
      LOP_ORN = 3'd4,
      LOP_MVN = 3'd5,
      LOP_TST = 3'd6,
      LOP_RSV = 3'd7
   } lop_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
   } lflags_t;

   function automatic logic lop_writes(input lop_e op);
      return (op != LOP_TST) && (op != LOP_RSV);
   endfunction
endpackage

// File: rtl/lu_bitop_core.sv
module lu_bitop_core
   import lu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  lop_e             op_i,
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   output logic [WIDTH-1:0] value_o
);
   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_bit
         logic a_b, b_b;
         assign a_b = opa_i[gi];
         assign b_b = opb_i[gi];
         always_comb begin
            unique case (op_i)
               LOP_AND, LOP_TST: value_o[gi] = a_b & b_b;
               LOP_ORR:          value_o[gi] = a_b | b_b;
               LOP_EOR:          value_o[gi] = a_b ^ b_b;
               LOP_BIC:          value_o[gi] = a_b & ~b_b;
               LOP_ORN:          value_o[gi] = a_b | ~b_b;
               LOP_MVN:          value_o[gi] = ~b_b;
               default:          value_o[gi] = 1'b0;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/lu_flag_eval.sv
module lu_flag_eval
   import lu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] value_i,
   input  logic             carry_i,
   output lflags_t          flags_o
);
   localparam int MSB = WIDTH - 1;
   always_comb begin
      flags_o.n = value_i[MSB];
      flags_o.z = (value_i == '0);
      flags_o.c = carry_i;
   end
endmodule

// File: rtl/bitlogic_unit.sv
module bitlogic_unit
   import lu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_i,
   input  logic [2:0]       op_i,
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   input  logic             set_flags_i,
   input  logic             shift_carry_i,
   output logic [WIDTH-1:0] result_o,
   output logic             result_we_o,
   output logic             flag_n_o,
   output logic             flag_z_o,
   output logic             flag_c_o
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("bitlogic_unit: WIDTH must be at least 2");
      end
   endgenerate

   lop_e             op;
   logic [WIDTH-1:0] value;
   lflags_t          next_flags;
   lflags_t          flags_q;
   logic             do_write;
   logic             do_flags;

   assign op = lop_e'(op_i);

   lu_bitop_core #(.WIDTH(WIDTH)) core_i (
      .op_i    (op),
      .opa_i   (opa_i),
      .opb_i   (opb_i),
      .value_o (value)
   );

   lu_flag_eval #(.WIDTH(WIDTH)) flag_i (
      .value_i (value),
      .carry_i (shift_carry_i),
      .flags_o (next_flags)
   );

   assign do_write = valid_i && lop_writes(op);
   assign do_flags = valid_i && (op != LOP_RSV) && (set_flags_i || (op == LOP_TST));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_o    <= '0;
         result_we_o <= 1'b0;
         flags_q     <= '0;
      end else begin
         result_we_o <= do_write;
         if (do_write) result_o <= value;
         if (do_flags) flags_q <= next_flags;
      end
   end

   assign flag_n_o = flags_q.n;
   assign flag_z_o = flags_q.z;
   assign flag_c_o = flags_q.c;
endmodule

// File: rtl/bitlogic_unit_chk.sv
module bitlogic_unit_chk #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             valid_i,
   input logic [2:0]       op_i,
   input logic             set_flags_i,
   input logic             shift_carry_i,
   input logic [WIDTH-1:0] result_o,
   input logic             result_we_o,
   input logic             flag_n_o,
   input logic             flag_z_o,
   input logic             flag_c_o
);
   logic wr_op, fl_op;
   assign wr_op = valid_i && (op_i < 3'd6);
   assign fl_op = valid_i && (op_i != 3'd7) && (set_flags_i || op_i == 3'd6);

   a_r5_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_op |=> $stable({flag_n_o, flag_z_o, flag_c_o}));

   a_r6_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == 3'd6) |=> (!result_we_o && $stable(result_o)));

   a_r7_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_op && set_flags_i) |=> (flag_z_o == (result_o == '0)));

   a_r7_neg_tracks_msb: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_op && set_flags_i) |=> (flag_n_o == result_o[WIDTH-1]));

   a_r8_carry_copy: assert property (@(posedge clk) disable iff (!rst_n)
      fl_op |=> (flag_c_o == $past(shift_carry_i)));

   a_r10_write_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_op |=> (!result_we_o && $stable(result_o)));

   a_r11_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == 3'd7) |=> (!result_we_o && $stable({flag_n_o, flag_z_o, flag_c_o})));
endmodule

bind bitlogic_unit bitlogic_unit_chk #(.WIDTH(WIDTH)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .valid_i       (valid_i),
   .op_i          (op_i),
   .set_flags_i   (set_flags_i),
   .shift_carry_i (shift_carry_i),
   .result_o      (result_o),
   .result_we_o   (result_we_o),
   .flag_n_o      (flag_n_o),
   .flag_z_o      (flag_z_o),
   .flag_c_o      (flag_c_o)
);

// File: tb/bitlogic_unit_tb_top.sv
module bitlogic_unit_tb_top;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         valid_i = 1'b0;
   logic [2:0]   op_i = '0;
   logic [W-1:0] opa_i = '0, opb_i = '0;
   logic         set_flags_i = 1'b0, shift_carry_i = 1'b0;
   logic [W-1:0] result_o;
   logic         result_we_o, flag_n_o, flag_z_o, flag_c_o;

   int n_checks = 0;
   int n_fails  = 0;

   logic [W-1:0] m_res;
   logic         m_we, m_n, m_z, m_c;
   logic [31:0]  rng = 32'h1234_5678;

   always #4 clk = ~clk;

   bitlogic_unit #(.WIDTH(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
      .opa_i(opa_i), .opb_i(opb_i), .set_flags_i(set_flags_i),
      .shift_carry_i(shift_carry_i), .result_o(result_o),
      .result_we_o(result_we_o), .flag_n_o(flag_n_o),
      .flag_z_o(flag_z_o), .flag_c_o(flag_c_o)
   );

   function automatic logic [W-1:0] ref_val(input logic [2:0] op, input logic [W-1:0] a, b);
      case (op)
         3'd0, 3'd6: return a & b;
         3'd1: return a | b;
         3'd2: return a ^ b;
         3'd3: return a & ~b;
         3'd4: return a | ~b;
         3'd5: return ~b;
         default: return '0;
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] op);
      case (op)
         3'd0, 3'd1, 3'd2: return "R1";
         3'd3: return "R2";
         3'd4: return "R3";
         3'd5: return "R4";
         3'd6: return "R6";
         default: return "R11";
      endcase
   endfunction

   task automatic chk(input string req, input string what, input logic [W-1:0] act, exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic compare_all(input string rres, input string rfl);
      chk(rres, "result", result_o, m_res);
      chk("R10", "write enable", {31'b0, result_we_o}, {31'b0, m_we});
      chk(rfl, "flag N (R7)", {31'b0, flag_n_o}, {31'b0, m_n});
      chk(rfl, "flag Z (R7)", {31'b0, flag_z_o}, {31'b0, m_z});
      chk(rfl, "flag C (R8)", {31'b0, flag_c_o}, {31'b0, m_c});
   endtask

   task automatic step(input logic v, input logic [2:0] op, input logic [W-1:0] a, b,
                       input logic sf, input logic cy);
      logic [W-1:0] val;
      logic         wr, fl;
      @(negedge clk);
      valid_i = v; op_i = op; opa_i = a; opb_i = b; set_flags_i = sf; shift_carry_i = cy;
      val = ref_val(op, a, b);
      wr  = v && (op < 3'd6);
      fl  = v && (op != 3'd7) && (sf || op == 3'd6);
      @(posedge clk);
      #1;
      m_we = wr;
      if (wr) m_res = val;
      if (fl) begin
         m_n = val[W-1];
         m_z = (val == '0);
         m_c = cy;
      end
      compare_all(v ? req_of(op) : "R10", fl ? "R7" : "R5");
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      return y ^ (y << 5);
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      m_res = '0; m_we = 0; m_n = 0; m_z = 0; m_c = 0;
      repeat (3) @(posedge clk);
      #1;
      compare_all("R9", "R9");
      @(negedge clk);
      rst_n = 1'b1;
      // R1 basic ops with flag update
      step(1, 3'd0, 32'hF0F0_1234, 32'h0FF0_FF00, 1, 1);
      step(1, 3'd1, 32'h8000_0000, 32'h0000_0001, 1, 0);
      step(1, 3'd2, 32'hAAAA_5555, 32'hAAAA_5555, 1, 1);   // zero result, Z=1
      // R2 bit clear
      step(1, 3'd3, 32'hFFFF_FFFF, 32'h0000_00FF, 0, 1);
      // R3 or-not
      step(1, 3'd4, 32'h0000_0000, 32'h0000_0000, 1, 0);
      // R4: opa has no effect
      step(1, 3'd5, 32'h1234_5678, 32'h0F0F_0F0F, 1, 1);
      step(1, 3'd5, 32'hDEAD_BEEF, 32'h0F0F_0F0F, 1, 0);
      // R6 test with one-hot mask, bit clear -> Z=1 and bit set -> Z=0
      step(1, 3'd6, 32'h0000_00BF, 32'h0000_0040, 0, 1);
      step(1, 3'd6, 32'h8000_0040, 32'h8000_0040, 0, 0);
      // R5: flags must hold without set_flags, valid low
      step(1, 3'd0, 32'h0, 32'h0, 0, 1);
      step(0, 3'd6, 32'h0, 32'hFFFF_FFFF, 1, 1);
      // R11 reserved code
      step(1, 3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1);
      for (int i = 0; i < 400; i++) begin
         logic [W-1:0] a, b;
         logic [31:0] ctl;
         rng = nxt(rng); a = rng;
         rng = nxt(rng); b = rng;
         rng = nxt(rng); ctl = rng;
         if (ctl[9:8] == 2'b00) b = 32'h1 << ctl[14:10];
         step(ctl[7:4] != 4'h0, ctl[2:0], a, b, ctl[3], ctl[16]);
      end
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      m_res = '0; m_we = 0; m_n = 0; m_z = 0; m_c = 0;
      compare_all("R9", "R9");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule